// File: doc/BRIEF.md
# Snooping Coherence Controller for a Single Shared Line

This block models one memory line that a small group of cores share. Each core holds a private write-back copy of the line: a data word plus three state bits (valid, exclusive, dirty). A backing memory word sits on the same snoop bus. Each cycle, while the bus is idle, one core may issue a read or a whole-line write. The controller keeps every copy coherent and returns the data read (or, for a write, the data written).

A run-time policy input selects how writes reach the other copies. In invalidate mode, a write removes all other copies. In update mode, a write overwrites the other valid copies in place. Both policies run on the same engine. A saturating counter adds one for every bus transaction, which gives an exact traffic figure for comparing the two policies on the same request stream.

Hits complete in a single cycle. Each bus transaction is a read fill or a write broadcast. It occupies a fixed two-cycle bus window, and `busy` is high during that window.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset, every copy is invalid, `mem_word` equals the `MEM_INIT` parameter, `evt_count` is 0, and both `busy` and `rsp_valid` are low.
- R2: A read to an invalid copy is a miss. `busy` is high for the two cycles after acceptance, `rsp_valid` pulses in the third cycle with the current line value, and `evt_count` rises by one. The copy is then valid, so a further read by that core is a hit.
- R3: With `policy_update`=0, a write by a core that is not the exclusive holder costs one bus transaction and one event, however many other copies exist. Every other copy becomes invalid, and the writer becomes the exclusive, dirty holder.
- R4: A hit completes with `rsp_valid` in the cycle after acceptance, with no `busy` and no event. A hit is either a read to a valid copy or, with `policy_update`=0, a write by the exclusive holder.
- R5: On a read miss while another core holds the line dirty, that core supplies the data and memory is written back in the same transaction. The supplier becomes shared and clean, so its next write must go over the bus again.
- R6: Writes never change `mem_word`. Memory changes only at the end of a read miss that is served by a dirty holder.
- R7: With `policy_update`=1, every write is a bus transaction counting one event. All other valid copies take the new value and stay valid, so their later reads hit. Invalid copies stay invalid.
- R8: `evt_count` is `CNT_W` bits wide and stops at its all-ones value instead of wrapping.
- R9: `policy_update` is sampled only while the bus is idle. A change made during a transaction does not affect that transaction, and it takes effect once the bus is idle again.
- R10: A request presented while `busy` is high is dropped. It produces no response, no event and no change to any copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_core | input | IDX_W | Index of the requesting core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Line value for a write |
| policy_update | input | 1 | 0 = invalidate others on write, 1 = update others on write |
| busy | output | 1 | A bus transaction is in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Read data, or the written value for a write |
| mem_word | output | DATA_W | Current backing memory value |
| evt_count | output | CNT_W | Saturating bus-event count |

## Verification
The bench builds the block with three cores, 8-bit data, a memory reset value of 0x05 and a 4-bit event counter. Three cores are enough to show one invalidate broadcast removing two sharers at once, and to show a third core filling from a dirty holder under update mode. The narrow counter lets an ordinary request sequence drive `evt_count` to its ceiling, so the saturation case is reached. The same stream also switches policy in the middle of a write and presents a stray request while the bus is busy.

// File: rtl/coh_pkg.sv
// Package coh_pkg
// Shared types for the single-line coherence controller.
// Assumes: one line, one request per cycle, whole-line writes.
package coh_pkg;

    // Phases of the shared bus: idle, then a fixed two-cycle transaction.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } bus_phase_t;

    // Actions the copy bank applies to every private copy at once.
    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_FILL      = 3'd1,
        OP_WR_LOCAL  = 3'd2,
        OP_WR_INVAL  = 3'd3,
        OP_WR_UPDATE = 3'd4
    } line_op_t;

    // State held by one private copy.
    typedef struct packed {
        logic vld;
        logic excl;
        logic dirty;
    } copy_state_t;

endpackage

// File: rtl/coh_copy_bank.sv
// Module coh_copy_bank
// Holds the private copy (state and data word) of every core. Each copy
// decides its own next state from the bank-wide operation and whether it
// is the requester.
// Assumes: op is presented for exactly one cycle per completed action.
module coh_copy_bank
    import coh_pkg::*;
#(
    parameter int N_CORES = 3,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  line_op_t                       op,
    input  logic [IDX_W-1:0]               op_core,
    input  logic [DATA_W-1:0]              op_data,
    output logic [N_CORES-1:0]             vld_o,
    output logic [N_CORES-1:0]             excl_o,
    output logic [N_CORES-1:0]             dirty_o,
    output logic [N_CORES-1:0][DATA_W-1:0] data_o
);

    for (genvar g = 0; g < N_CORES; g++) begin : g_copy
        copy_state_t       st;
        logic [DATA_W-1:0] dat;
        logic              me;

        assign me = (op_core == IDX_W'(g));

        // Apply the current bank operation to this copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st  <= '0;
                dat <= '0;
            end else begin
                unique case (op)
                    OP_FILL: begin
                        if (me) begin
                            st  <= '{vld: 1'b1, excl: 1'b0, dirty: 1'b0};
                            dat <= op_data;
                        end else begin
                            st.excl  <= 1'b0;
                            st.dirty <= 1'b0;
                        end
                    end
                    OP_WR_LOCAL: begin
                        if (me) dat <= op_data;
                    end
                    OP_WR_INVAL: begin
                        if (me) begin
                            st  <= '{vld: 1'b1, excl: 1'b1, dirty: 1'b1};
                            dat <= op_data;
                        end else begin
                            st <= '0;
                        end
                    end
                    OP_WR_UPDATE: begin
                        if (me) begin
                            st  <= '{vld: 1'b1, excl: 1'b0, dirty: 1'b1};
                            dat <= op_data;
                        end else if (st.vld) begin
                            st.excl  <= 1'b0;
                            st.dirty <= 1'b0;
                            dat      <= op_data;
                        end
                    end
                    default: ;
                endcase
            end
        end

        assign vld_o[g]   = st.vld;
        assign excl_o[g]  = st.excl;
        assign dirty_o[g] = st.dirty;
        assign data_o[g]  = dat;

        // R3
        sole_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st.excl |-> ($countones(vld_o) == 1));
    end

    // R5
    single_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dirty_o) <= 1);

endmodule

// File: rtl/coh_sat_counter.sv
// Module coh_sat_counter
// Counts bus events and holds at the all-ones value.
// Assumes: at most one increment per cycle.
module coh_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Add one per event unless already at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
    // R8
    count_hold_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt == CNT_MAX));
    // R4
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt));

endmodule

// File: rtl/coh_snoop_ctrl.sv
// Module coh_snoop_ctrl
// Top of the single-line snooping coherence controller. It accepts one
// read or write per idle cycle, serves hits at once, and runs misses and
// write broadcasts as a fixed two-cycle bus transaction. The policy input
// chooses between invalidating and updating the other copies on a write.
// Assumes: req_core is below N_CORES; writes cover the whole line.
module coh_snoop_ctrl
    import coh_pkg::*;
#(
    parameter int                N_CORES  = 3,
    parameter int                DATA_W   = 32,
    parameter int                CNT_W    = 16,
    parameter logic [DATA_W-1:0] MEM_INIT = '0,
    localparam int               IDX_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_core,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              policy_update,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [DATA_W-1:0] mem_word,
    output logic [CNT_W-1:0]  evt_count
);

    bus_phase_t                 phase;
    logic                       pol_q;
    logic [IDX_W-1:0]           lat_core;
    logic                       lat_write;
    logic [DATA_W-1:0]          lat_data;
    logic [DATA_W-1:0]          mem_q;
    logic                       rsp_valid_q;
    logic [DATA_W-1:0]          rsp_data_q;

    logic [N_CORES-1:0]             vld, excl, dirty;
    logic [N_CORES-1:0][DATA_W-1:0] cdata;

    logic              eff_pol, accept, fast;
    logic              any_dirty;
    logic [DATA_W-1:0] fill_data;
    line_op_t          op;
    logic [IDX_W-1:0]  op_core;
    logic [DATA_W-1:0] op_data;

    // The policy input counts only while idle; otherwise the latched one.
    assign eff_pol = (phase == PH_IDLE) ? policy_update : pol_q;
    assign accept  = req_valid && (phase == PH_IDLE);
    assign fast    = accept && (req_write ? (!eff_pol && excl[req_core])
                                          : vld[req_core]);

    // Fill source: the dirty holder if one exists, otherwise memory.
    always_comb begin
        any_dirty = |dirty;
        fill_data = mem_q;
        for (int i = 0; i < N_CORES; i++) begin
            if (dirty[i]) fill_data = cdata[i];
        end
    end

    // Select the bank operation: completion of a transaction or a local write.
    always_comb begin
        op      = OP_NONE;
        op_core = lat_core;
        op_data = lat_data;
        if (phase == PH_DATA) begin
            if (lat_write) op = pol_q ? OP_WR_UPDATE : OP_WR_INVAL;
            else begin
                op      = OP_FILL;
                op_data = fill_data;
            end
        end else if (fast && req_write) begin
            op      = OP_WR_LOCAL;
            op_core = req_core;
            op_data = req_wdata;
        end
    end

    // Bus sequencer, request latch, memory word and response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            pol_q       <= 1'b0;
            lat_core    <= '0;
            lat_write   <= 1'b0;
            lat_data    <= '0;
            mem_q       <= MEM_INIT;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    pol_q <= policy_update;
                    if (fast) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= req_write ? req_wdata : cdata[req_core];
                    end else if (accept) begin
                        phase     <= PH_ADDR;
                        lat_core  <= req_core;
                        lat_write <= req_write;
                        lat_data  <= req_wdata;
                    end
                end
                PH_ADDR: phase <= PH_DATA;
                PH_DATA: begin
                    phase       <= PH_IDLE;
                    rsp_valid_q <= 1'b1;
                    rsp_data_q  <= lat_write ? lat_data : fill_data;
                    if (!lat_write && any_dirty) mem_q <= fill_data;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    coh_copy_bank #(
        .N_CORES (N_CORES),
        .DATA_W  (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .op_core (op_core),
        .op_data (op_data),
        .vld_o   (vld),
        .excl_o  (excl),
        .dirty_o (dirty),
        .data_o  (cdata)
    );

    coh_sat_counter #(
        .CNT_W (CNT_W)
    ) u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (phase == PH_DATA),
        .cnt   (evt_count)
    );

    assign busy      = (phase != PH_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign mem_word  = mem_q;

    // R2
    bus_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
    // R2
    bus_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> ##1 (!busy && rsp_valid));
    // R9
    policy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pol_q));
    // R6
    mem_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_q != $past(mem_q)) |-> $past(phase == PH_DATA && !lat_write));
    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |=> $stable(lat_core) && $stable(lat_data));

endmodule

// File: tb/coh_snoop_ctrl_bench.sv
// Bench for coh_snoop_ctrl: a driver task queues the expected response of
// each request; a monitor pops and compares as responses appear.
module coh_snoop_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_core = '0;
    logic       req_write = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       pol = 1'b0;
    logic       busy, rsp_valid;
    logic [7:0] rsp_data, mem_word;
    logic [3:0] evt_count;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    bit  finished = 1'b0;

    typedef struct {
        logic [7:0] data;
        int         lat;
        int         cnt;
        string      tag;
        int         t0;
    } exp_t;

    exp_t sb[$];
    exp_t mon_it;

    coh_snoop_ctrl #(
        .N_CORES  (3),
        .DATA_W   (8),
        .CNT_W    (4),
        .MEM_INIT (8'h05)
    ) u_coh_snoop_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_core      (req_core),
        .req_write     (req_write),
        .req_wdata     (req_wdata),
        .policy_update (pol),
        .busy          (busy),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data),
        .mem_word      (mem_word),
        .evt_count     (evt_count)
    );

    always #10ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, bit ok, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every response must match the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk("R10 unexpected response", 1'b0, int'(rsp_data), 0);
            end else begin
                mon_it = sb.pop_front();
                chk({mon_it.tag, " data"}, rsp_data == mon_it.data,
                    int'(rsp_data), int'(mon_it.data));
                chk({mon_it.tag, " latency"}, (cyc - mon_it.t0) == mon_it.lat,
                    cyc - mon_it.t0, mon_it.lat);
                chk({mon_it.tag, " events"}, int'(evt_count) == mon_it.cnt,
                    int'(evt_count), mon_it.cnt);
            end
        end
    end

    // Driver: mode 1 flips the policy mid-transaction, mode 2 presents a
    // stray write from core 0 while the bus is busy.
    task automatic issue(int core, bit wr, logic [7:0] d, logic [7:0] exp_d,
                         bit slow, int exp_cnt, string tag, int mode = 0);
        exp_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1;
        req_core  = core[1:0];
        req_write = wr;
        req_wdata = d;
        it.data = exp_d;
        it.lat  = slow ? 3 : 1;
        it.cnt  = exp_cnt;
        it.tag  = tag;
        it.t0   = cyc;
        sb.push_back(it);
        @(negedge clk);
        if (mode == 2) begin
            chk("R10 bus busy at stray request", busy == 1'b1, int'(busy), 1);
            req_core  = 2'd0;
            req_write = 1'b1;
            req_wdata = 8'hEE;
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (mode == 1) pol = ~pol;
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy low", busy == 1'b0, int'(busy), 0);
        chk("R1 rsp_valid low", rsp_valid == 1'b0, int'(rsp_valid), 0);
        chk("R1 count zero", evt_count == 4'd0, int'(evt_count), 0);
        chk("R1 memory init", mem_word == 8'h05, int'(mem_word), 5);
        rst_n = 1'b1;

        // Invalidate policy: cold misses, then a hit.
        issue(0, 0, 8'h00, 8'h05, 1, 1, "R1 R2 core0 cold read");
        issue(0, 0, 8'h00, 8'h05, 0, 1, "R2 R4 core0 read hit");
        issue(1, 0, 8'h00, 8'h05, 1, 2, "R2 core1 read miss");
        issue(2, 0, 8'h00, 8'h05, 1, 3, "R2 core2 read miss");
        // One broadcast removes two sharers.
        issue(0, 1, 8'h09, 8'h09, 1, 4, "R3 core0 shared write");
        chk("R6 memory after write", mem_word == 8'h05, int'(mem_word), 5);
        issue(0, 1, 8'h0A, 8'h0A, 0, 4, "R4 exclusive write");
        issue(0, 1, 8'h0B, 8'h0B, 0, 4, "R4 exclusive write again");
        chk("R6 memory after local writes", mem_word == 8'h05, int'(mem_word), 5);
        issue(1, 0, 8'h00, 8'h0B, 1, 5, "R5 R3 core1 fill from owner");
        chk("R5 memory written back", mem_word == 8'h0B, int'(mem_word), 11);
        issue(2, 0, 8'h00, 8'h0B, 1, 6, "R3 core2 refill");
        issue(0, 1, 8'h0C, 8'h0C, 1, 7, "R5 former owner writes again");

        // Update policy.
        pol = 1'b1;
        issue(1, 1, 8'h21, 8'h21, 1, 8, "R7 core1 update write");
        issue(0, 0, 8'h00, 8'h21, 0, 8, "R7 core0 hit after update");
        issue(2, 0, 8'h00, 8'h21, 1, 9, "R7 R5 invalid core2 misses");
        chk("R5 memory after update fill", mem_word == 8'h21, int'(mem_word), 33);
        issue(1, 1, 8'h22, 8'h22, 1, 10, "R7 every write broadcasts");
        issue(0, 0, 8'h00, 8'h22, 0, 10, "R7 core0 hit");
        issue(2, 0, 8'h00, 8'h22, 0, 10, "R7 core2 hit");
        chk("R6 memory under update", mem_word == 8'h21, int'(mem_word), 33);

        // Policy flipped to invalidate during an update write.
        issue(2, 1, 8'h31, 8'h31, 1, 11, "R9 update write, policy flipped", 1);
        chk("R9 policy now invalidate", pol == 1'b0, int'(pol), 0);
        issue(0, 0, 8'h00, 8'h31, 0, 11, "R9 core0 still valid");
        issue(0, 1, 8'h40, 8'h40, 1, 12, "R9 R3 invalidate write");
        issue(1, 0, 8'h00, 8'h40, 1, 13, "R3 R5 core1 miss");
        chk("R5 memory 0x40", mem_word == 8'h40, int'(mem_word), 64);

        // Stray request while busy is dropped.
        issue(2, 0, 8'h00, 8'h40, 1, 14, "R10 core2 miss with stray", 2);
        issue(0, 0, 8'h00, 8'h40, 0, 14, "R10 core0 unchanged by stray");

        // Counter ceiling.
        issue(1, 1, 8'h50, 8'h50, 1, 15, "R8 count reaches max");
        issue(0, 0, 8'h00, 8'h50, 1, 15, "R8 count holds");
        issue(2, 0, 8'h00, 8'h50, 1, 15, "R8 count still holds");
        chk("R8 final count", evt_count == 4'hF, int'(evt_count), 15);

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule